// File: doc/BRIEF.md
# Page-Mode DRAM Cycle Controller

This controller sits between a processor bus and a page-mode DRAM. The processor announces the type of each bus cycle one clock ahead, on an active-low request line and a sequential line. The controller stores that forecast in its state register and acts on it in the next clock. It drives active-low row and column strobes, and a multiplexed DRAM address that carries either the row or the column part of the word address.

A sequential access that stays inside the open row costs one clock. An access that must open a row costs two clocks, and the controller stretches the processor by pulling the active-low wait line for the first of them. Such an access is a non-sequential one, a sequential one after the row was closed, or a sequential one that steps off the last column of the page. An internal cycle that is forecast to be followed by a sequential one carries the same address. The controller opens that row during the internal cycle, so the sequential cycle that follows completes in one clock. Internal cycles and coprocessor cycles otherwise leave the DRAM untouched.

The FSM has four states:
- `ST_IDLE`: after reset, and for coprocessor cycles; no strobes.
- `ST_INTERNAL`: an internal cycle; the early row opens here when a sequential cycle is forecast.
- `ST_ROW`: the row clock of a full access, with wait active.
- `ST_COL`: the column clock of any access.

The transitions are:
- `ST_ROW` always goes to `ST_COL`.
- From any other state, the forecast code picks the next state:
  - a non-sequential code goes to `ST_ROW`;
  - a sequential code goes to `ST_COL` when coming from `ST_INTERNAL`, or from `ST_COL` with the present column not the last one; otherwise it goes to `ST_ROW`;
  - an internal code goes to `ST_INTERNAL`;
  - a coprocessor code goes to `ST_IDLE`.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held low, and in the first clock after it is released with no cycle forecast yet, ras_n, cas_n and wait_n are all high.
- R2: The cycle code {mreq_n, seq} means 00 = non-sequential, 01 = sequential, 10 = internal, 11 = coprocessor. The code present in one clock decides the strobes of the following clock.
- R3: A non-sequential cycle takes two clocks. In the first, ras_n=0, cas_n=1, wait_n=0 and dram_addr carries the row. In the second, ras_n=0, cas_n=0, wait_n=1 and dram_addr carries the column. This holds even when a row is already open.
- R4: A sequential cycle that follows a column clock whose address column was not all ones takes one clock, with ras_n=0, cas_n=0, wait_n=1 and the new column on dram_addr.
- R5: A sequential cycle that follows a column clock whose address column was all ones (last word of the page) is performed as the two-clock full access of R3, using the new address.
- R6: A sequential cycle that follows a coprocessor cycle, when the row has been closed, is performed as the two-clock full access of R3.
- R7: In an internal cycle whose forecast code is sequential, the controller drives ras_n=0, cas_n=1, wait_n=1 with the row of the present address. The sequential cycle that follows is then a single column clock with wait_n=1, even if its column is the last of the page.
- R8: Internal cycles not followed by a sequential cycle, and coprocessor cycles, keep ras_n, cas_n and wait_n high.
- R9: wait_n is low for exactly one clock per full access. The cycle code presented during that clock is ignored, and the column clock always follows.
- R10: The column is the low log2(PAGE_WORDS) bits of the word address. The row is the remaining upper bits. Both are zero-extended to the dram_addr width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq_n | input | 1 | Forecast code bit: low for a memory cycle |
| seq | input | 1 | Forecast code bit: high for a sequential cycle |
| addr | input | ADDR_W | Word address of the present cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| wait_n | output | 1 | Processor stretch, active low |
| dram_addr | output | max(ROW_W, COL_W) | Multiplexed row or column address |

## Verification
The early row opening and the page-end test can land in the same clock. This happens when an internal cycle opens the row for an address in the last column, and a second sequential cycle is already forecast during the column clock that follows. The bench provokes this by placing an internal cycle on a last-column address and following it with two sequential cycles. It judges the result by three checks: the first column clock must show no wait, the next clock must show exactly one wait clock carrying the next row, and the column clock after that must carry column zero.

// File: rtl/dram_pm_pkg.sv
package dram_pm_pkg;

    // Cycle code carried on {mreq_n, seq}.
    typedef enum logic [1:0] {
        CY_NSEQ = 2'b00,
        CY_SEQ  = 2'b01,
        CY_INT  = 2'b10,
        CY_COP  = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INTERNAL,
        ST_ROW,
        ST_COL
    } st_e;

endpackage

// File: rtl/dram_pm_decode.sv
module dram_pm_decode
    import dram_pm_pkg::*;
(
    input  logic mreq_n,
    input  logic seq,
    output cyc_e cyc
);
    assign cyc = cyc_e'({mreq_n, seq});
endmodule

// File: rtl/dram_pm_split.sv
module dram_pm_split #(
    parameter int ADDR_W = 20,
    parameter int COL_W  = 9,
    parameter int DA_W   = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DA_W-1:0]   row_a,
    output logic [DA_W-1:0]   col_a,
    output logic              last_col
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic [ROW_W-1:0] row_bits;
    logic [COL_W-1:0] col_bits;

    assign row_bits = addr[ADDR_W-1:COL_W];
    assign col_bits = addr[COL_W-1:0];
    assign row_a    = DA_W'(row_bits);
    assign col_a    = DA_W'(col_bits);
    assign last_col = &col_bits;
endmodule

// File: rtl/dram_pm_fsm.sv
module dram_pm_fsm
    import dram_pm_pkg::*;
#(
    parameter int DA_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cyc_e            cyc,
    input  logic            last_col,
    input  logic [DA_W-1:0] row_a,
    input  logic [DA_W-1:0] col_a,
    output logic            ras_n,
    output logic            cas_n,
    output logic            wait_n,
    output logic [DA_W-1:0] dram_addr
);
    st_e st, st_nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Transitions: the forecast code is consumed only when wait_n is high.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_ROW: st_nxt = ST_COL;
            ST_IDLE, ST_INTERNAL, ST_COL: begin
                unique case (cyc)
                    CY_NSEQ: st_nxt = ST_ROW;
                    CY_SEQ: begin
                        if (st == ST_INTERNAL || (st == ST_COL && !last_col))
                            st_nxt = ST_COL;
                        else
                            st_nxt = ST_ROW;
                    end
                    CY_INT: st_nxt = ST_INTERNAL;
                    CY_COP: st_nxt = ST_IDLE;
                endcase
            end
        endcase
    end

    // Outputs.
    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        wait_n    = 1'b1;
        dram_addr = row_a;
        unique case (st)
            ST_IDLE: ;
            ST_INTERNAL: ras_n = (cyc != CY_SEQ);
            ST_ROW: begin
                ras_n  = 1'b0;
                wait_n = 1'b0;
            end
            ST_COL: begin
                ras_n     = 1'b0;
                cas_n     = 1'b0;
                dram_addr = col_a;
            end
        endcase
    end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
    parameter int ADDR_W     = 20,
    parameter int PAGE_WORDS = 512,
    localparam int COL_W     = $clog2(PAGE_WORDS),
    localparam int ROW_W     = ADDR_W - COL_W,
    localparam int DA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              seq,
    input  logic [ADDR_W-1:0] addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              wait_n,
    output logic [DA_W-1:0]   dram_addr
);
    import dram_pm_pkg::*;

    cyc_e            cyc;
    logic [DA_W-1:0] row_a;
    logic [DA_W-1:0] col_a;
    logic            last_col;

    dram_pm_decode u_dec (
        .mreq_n (mreq_n),
        .seq    (seq),
        .cyc    (cyc)
    );

    dram_pm_split #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .DA_W   (DA_W)
    ) u_split (
        .addr     (addr),
        .row_a    (row_a),
        .col_a    (col_a),
        .last_col (last_col)
    );

    dram_pm_fsm #(
        .DA_W (DA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (cyc),
        .last_col  (last_col),
        .row_a     (row_a),
        .col_a     (col_a),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .wait_n    (wait_n),
        .dram_addr (dram_addr)
    );
endmodule

// File: rtl/dram_pm_checker.sv
module dram_pm_checker #(
    parameter int ADDR_W = 20,
    parameter int COL_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mreq_n,
    input logic              seq,
    input logic [ADDR_W-1:0] addr,
    input logic              ras_n,
    input logic              cas_n,
    input logic              wait_n
);
    logic fc_seq;
    logic at_last;
    assign fc_seq  = ({mreq_n, seq} == 2'b01);
    assign at_last = &addr[COL_W-1:0];

    assert_wait_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |=> (wait_n && !cas_n && !ras_n));

    assert_full_on_nseq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_n && {mreq_n, seq} == 2'b00) |=> (!wait_n && cas_n && !ras_n));

    assert_page_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_n && !cas_n && fc_seq && !at_last) |=> (wait_n && !cas_n));

    assert_page_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_n && !cas_n && fc_seq && at_last) |=> !wait_n);

    assert_early_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_n && cas_n && !ras_n) |=> (wait_n && !cas_n));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_n && mreq_n) |=> (cas_n && wait_n));

    assert_cas_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
endmodule

bind dram_page_ctrl dram_pm_checker #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mreq_n (mreq_n),
    .seq    (seq),
    .addr   (addr),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .wait_n (wait_n)
);

// File: tb/test_dram_page_ctrl.sv
module test_dram_page_ctrl;
    localparam int ADDR_W     = 20;
    localparam int PAGE_WORDS = 512;
    localparam int COL_W      = $clog2(PAGE_WORDS);
    localparam int ROW_W      = ADDR_W - COL_W;
    localparam int DA_W       = (ROW_W > COL_W) ? ROW_W : COL_W;

    // {mreq_n, seq}
    localparam logic [1:0] C_N = 2'b00, C_S = 2'b01, C_I = 2'b10, C_C = 2'b11;
    // {ras_n, cas_n, wait_n}
    localparam logic [2:0] Q_IDLE = 3'b111, Q_ROW = 3'b010,
                           Q_COL = 3'b001, Q_EARLY = 3'b011;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mreq_n = 1'b1;
    logic              seq = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              ras_n, cas_n, wait_n;
    logic [DA_W-1:0]   dram_addr;

    int vectors = 0;
    int miscmp  = 0;

    always #4 clk = ~clk;

    dram_page_ctrl #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) i_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .seq(seq), .addr(addr),
        .ras_n(ras_n), .cas_n(cas_n), .wait_n(wait_n), .dram_addr(dram_addr)
    );

    function automatic logic [ADDR_W-1:0] mk(input int r, input int c);
        return ADDR_W'((r << COL_W) | c);
    endfunction
    function automatic logic [DA_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return DA_W'(a >> COL_W);
    endfunction
    function automatic logic [DA_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return DA_W'(a[COL_W-1:0]);
    endfunction

    // Present the code for the next cycle and the address of this one, then sample.
    task automatic step(input logic [1:0] code, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        {mreq_n, seq} = code;
        addr = a;
        #2;
    endtask

    task automatic check(input string req, input logic [2:0] exp_q,
                         input logic [DA_W-1:0] exp_a, input bit use_a);
        vectors++;
        if ({ras_n, cas_n, wait_n} !== exp_q || (use_a && dram_addr !== exp_a)) begin
            miscmp++;
            $display("FAIL %s: ras/cas/wait=%b addr=%h, expected %b addr=%h",
                     req, {ras_n, cas_n, wait_n}, dram_addr, exp_q, exp_a);
        end
    endtask

    task automatic t_reset;
        check("R1 during reset", Q_IDLE, '0, 1'b0);
        step(C_C, '0);
        rst_n = 1'b1;
        step(C_C, '0);
        check("R1 after reset", Q_IDLE, '0, 1'b0);
    endtask

    // Non-sequential access; an internal code shown during the wait clock is ignored.
    task automatic t_nseq;
        logic [ADDR_W-1:0] a = mk(3, 17);
        step(C_N, '0);
        step(C_I, a);
        check("R3 row clock", Q_ROW, row_of(a), 1'b1);
        step(C_C, a);
        check("R9 column after wait", Q_COL, col_of(a), 1'b1);
        step(C_C, '0);
        check("R2 coprocessor idle", Q_IDLE, '0, 1'b0);
    endtask

    task automatic t_page_mode;
        logic [ADDR_W-1:0] a = mk(5, PAGE_WORDS - 4);
        step(C_N, '0);
        step(C_S, a);
        check("R3 row", Q_ROW, row_of(a), 1'b1);
        step(C_S, a);
        check("R3 column", Q_COL, col_of(a), 1'b1);
        step(C_S, a + 1);
        check("R4 page mode 1", Q_COL, col_of(a + 1), 1'b1);
        step(C_C, a + 2);
        check("R4 page mode 2", Q_COL, col_of(a + 2), 1'b1);
        step(C_C, '0);
        check("R8 idle after", Q_IDLE, '0, 1'b0);
    endtask

    task automatic t_page_end;
        logic [ADDR_W-1:0] a = mk(6, PAGE_WORDS - 2);
        step(C_N, '0);
        step(C_S, a);
        step(C_S, a);
        check("R3 column", Q_COL, col_of(a), 1'b1);
        step(C_S, a + 1);
        check("R4 last column page mode", Q_COL, DA_W'(PAGE_WORDS - 1), 1'b1);
        step(C_C, a + 2);
        check("R5 page end row", Q_ROW, DA_W'(7), 1'b1);
        step(C_C, a + 2);
        check("R5 page end column", Q_COL, DA_W'(0), 1'b1);
        step(C_C, '0);
    endtask

    task automatic t_int_seq;
        logic [ADDR_W-1:0] b = mk(9, 40);
        step(C_I, '0);
        step(C_S, b);
        check("R7 early row", Q_EARLY, row_of(b), 1'b1);
        step(C_C, b);
        check("R7 single column", Q_COL, col_of(b), 1'b1);
        step(C_C, '0);
        check("R8 idle", Q_IDLE, '0, 1'b0);
    endtask

    // Early row on a last-column address, with a second sequential cycle forecast.
    task automatic t_coincide;
        logic [ADDR_W-1:0] b = mk(12, PAGE_WORDS - 1);
        step(C_I, '0);
        step(C_S, b);
        check("R7 early row last col", Q_EARLY, row_of(b), 1'b1);
        step(C_S, b);
        check("R7 no wait on last col", Q_COL, col_of(b), 1'b1);
        step(C_C, b + 1);
        check("R5 after early row", Q_ROW, DA_W'(13), 1'b1);
        step(C_C, b + 1);
        check("R10 column zero", Q_COL, DA_W'(0), 1'b1);
        step(C_C, '0);
    endtask

    task automatic t_int_only;
        step(C_I, '0);
        step(C_I, mk(2, 2));
        check("R8 internal then internal", Q_IDLE, '0, 1'b0);
        step(C_C, mk(2, 2));
        check("R8 internal then cop", Q_IDLE, '0, 1'b0);
        step(C_C, '0);
        check("R8 cop", Q_IDLE, '0, 1'b0);
    endtask

    task automatic t_seq_after_cop;
        logic [ADDR_W-1:0] a = mk(4, 10);
        step(C_N, '0);
        step(C_C, a);
        step(C_C, a);
        check("R3 column", Q_COL, col_of(a), 1'b1);
        step(C_S, '0);
        check("R6 row closed", Q_IDLE, '0, 1'b0);
        step(C_C, a + 1);
        check("R6 full access", Q_ROW, row_of(a + 1), 1'b1);
        step(C_C, a + 1);
        check("R6 column", Q_COL, col_of(a + 1), 1'b1);
        step(C_C, '0);
    endtask

    task automatic t_back_to_back;
        logic [ADDR_W-1:0] a = mk(20, 3);
        logic [ADDR_W-1:0] d = mk(ROW_W > 1 ? 1000 : 1, 300);
        step(C_N, '0);
        step(C_N, a);
        step(C_N, a);
        check("R3 first column", Q_COL, col_of(a), 1'b1);
        step(C_C, d);
        check("R3 open row full access", Q_ROW, row_of(d), 1'b1);
        step(C_C, d);
        check("R10 column split", Q_COL, DA_W'(300), 1'b1);
        step(C_C, '0);
    endtask

    initial begin
        #(8 * 50000);
        miscmp++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_nseq;
        t_page_mode;
        t_page_end;
        t_int_seq;
        t_coincide;
        t_int_only;
        t_seq_after_cop;
        t_back_to_back;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule